// File: doc/BRIEF.md
# Power-Good Latched Strap Decoder

This block reads a set of board configuration straps at the moment an active-low power-good signal is first qualified as asserted. From then on it holds the decoded clock-selection state. The straps are three frequency-select pins, two function-select pins and one clock-request select pin. From them the block derives four things:

- an encoded host-clock frequency;
- the source routed to a first output-pin pair;
- whether a second pin pair carries the spread-spectrum clock;
- whether a third pin pair serves as clock-request inputs or as an extra clock output.

The power-good input is synchronized and must stay low for two consecutive synchronized cycles before it counts. Sampling is one-shot: once the straps are captured, later movement on the straps or on power-good changes nothing. The exception is a test-mode input. While it is high, every qualified low on power-good captures the straps again. A sticky `locked_o` output shows that a capture has happened.

Top module: `strap_latch_decoder`

## Requirements
- R1: `pwrgd_n_i` passes through a two-stage synchronizer and must be seen low on two consecutive synchronized cycles before a capture. With `pwrgd_n_i` driven low before clock edge k, the captured straps and `locked_o` appear after edge k+3. A low pulse lasting one clock captures nothing.
- R2: `host_code_o` decodes `fs_i` (bit 2 = FSC, bit 1 = FSB, bit 0 = FSA) as follows: 101 gives 0 (100 MHz), 001 gives 1 (133 MHz), 011 gives 2 (166 MHz) and 010 gives 3 (200 MHz).
- R3: Any other `fs_i` code (000, 100, 110, 111) yields `host_code_o` = 0 and sets `strap_invalid_o`. The four valid codes clear it.
- R4: `pair_a_sel_o` decodes the function-select straps `fsel_i`: 00 and 01 give 0 (96 MHz dot clock), 10 gives 1 (27 MHz non-spread/spread) and 11 gives 2 (pair off/low).
- R5: `pair_b_sst_o` is 1 (100 MHz spread clock) only when the captured `fsel_i` is 00. Otherwise it is 0 (SRC0).
- R6: `creq_xclk_o` equals the captured `creq_sel_i`, where 0 means clock-request function and 1 means extra clock output.
- R7: Until the first capture, the outputs read as follows: `host_code_o` 0, `pair_a_sel_o` 0, `pair_b_sst_o` 1, `creq_xclk_o` 0, `strap_invalid_o` 0.
- R8: With `test_mode_i` low, after a capture all later changes on the straps and on `pwrgd_n_i` leave every output unchanged.
- R9: With `test_mode_i` high, each cycle in which power-good is qualified low captures the straps again. A strap change made before edge t is visible after edge t.
- R10: `locked_o` is registered, rises with the first capture and clears only on `rst_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwrgd_n_i | input | 1 | Active-low power-good, asynchronous |
| test_mode_i | input | 1 | Re-sampling enable |
| fs_i | input | 3 | Frequency-select straps {FSC,FSB,FSA} |
| fsel_i | input | 2 | Function-select straps |
| creq_sel_i | input | 1 | Clock-request / extra-clock select strap |
| host_code_o | output | 2 | Encoded host-clock frequency |
| pair_a_sel_o | output | 2 | Source of the first pin pair |
| pair_b_sst_o | output | 1 | Second pin pair carries spread clock |
| creq_xclk_o | output | 1 | Third pin pair is an extra clock output |
| strap_invalid_o | output | 1 | Undefined frequency code was captured |
| locked_o | output | 1 | Straps have been captured |

## Verification
Two functions can meet in one cycle: test mode being released and a fresh strap value arriving, both while power-good is still qualified low. In that cycle the capture path would take the new straps, and the lock path must refuse them. The bench provokes this by dropping `test_mode_i` and changing `fs_i` on the same falling edge after a test-mode capture. It then requires that the outputs keep the earlier decode on the next edge and for several cycles after. The full sweep of all 64 strap combinations also moves every strap and power-good right after each lock, which checks that the decode stays frozen.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    HOST_100 = 2'd0,
    HOST_133 = 2'd1,
    HOST_166 = 2'd2,
    HOST_200 = 2'd3
  } host_sel_e;

  typedef enum logic [1:0] {
    PA_DOT96 = 2'd0,
    PA_27M   = 2'd1,
    PA_OFF   = 2'd2
  } pair_a_e;

  typedef struct packed {
    logic [2:0] fs;
    logic [1:0] fsel;
    logic       creq;
  } strap_t;

  typedef struct packed {
    host_sel_e host;
    logic      bad;
  } host_dec_t;

  localparam strap_t STRAP_DEFAULT = '{fs: 3'b101, fsel: 2'b00, creq: 1'b0};

  function automatic host_dec_t decode_host(input logic [2:0] fs);
    host_dec_t r;
    r.bad  = 1'b0;
    unique case (fs)
      3'b101:  r.host = HOST_100;
      3'b001:  r.host = HOST_133;
      3'b011:  r.host = HOST_166;
      3'b010:  r.host = HOST_200;
      default: begin
        r.host = HOST_100;
        r.bad  = 1'b1;
      end
    endcase
    return r;
  endfunction

  function automatic pair_a_e decode_pair_a(input logic [1:0] fsel);
    pair_a_e r;
    unique case (fsel)
      2'b10:   r = PA_27M;
      2'b11:   r = PA_OFF;
      default: r = PA_DOT96;
    endcase
    return r;
  endfunction

  function automatic logic decode_pair_b_sst(input logic [1:0] fsel);
    return (fsel == 2'b00);
  endfunction

endpackage

// File: rtl/pg_qualifier.sv
module pg_qualifier #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_LEN    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrgd_n_i,
  output logic pg_low_o,
  output logic qual_valid_o
);
  localparam int CW = $clog2(QUAL_LEN) + 1;
  localparam logic [CW-1:0] SAT  = CW'(QUAL_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          low_cnt;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= pwrgd_n_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b1;
          else        sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  assign pg_low_o = ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_cnt <= '0;
    else if (!pg_low_o)        low_cnt <= '0;
    else if (low_cnt < SAT)    low_cnt <= low_cnt + 1'b1;
  end

  assign qual_valid_o = pg_low_o && (low_cnt >= SAT);
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   qual_valid_i,
  input  logic   test_mode_i,
  input  strap_t straps_i,
  output strap_t held_o,
  output logic   locked_o,
  output logic   capture_o
);
  assign capture_o = qual_valid_i && (!locked_o || test_mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_o   <= STRAP_DEFAULT;
      locked_o <= 1'b0;
    end else if (capture_o) begin
      held_o   <= straps_i;
      locked_o <= 1'b1;
    end
  end
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_pkg::*;
(
  input  strap_t     held_i,
  output logic [1:0] host_code_o,
  output logic       invalid_o,
  output logic [1:0] pair_a_o,
  output logic       pair_b_sst_o,
  output logic       creq_xclk_o
);
  host_dec_t hd;
  pair_a_e   pa;

  always_comb begin
    hd           = decode_host(held_i.fs);
    pa           = decode_pair_a(held_i.fsel);
    host_code_o  = hd.host;
    invalid_o    = hd.bad;
    pair_a_o     = pa;
    pair_b_sst_o = decode_pair_b_sst(held_i.fsel);
    creq_xclk_o  = held_i.creq;
  end
endmodule

// File: rtl/strap_latch_decoder.sv
module strap_latch_decoder
  import strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_LEN    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrgd_n_i,
  input  logic       test_mode_i,
  input  logic [2:0] fs_i,
  input  logic [1:0] fsel_i,
  input  logic       creq_sel_i,
  output logic [1:0] host_code_o,
  output logic [1:0] pair_a_sel_o,
  output logic       pair_b_sst_o,
  output logic       creq_xclk_o,
  output logic       strap_invalid_o,
  output logic       locked_o
);
  logic   pg_low;
  logic   qual_valid;
  logic   capture_evt;
  strap_t straps_now;
  strap_t held;

  assign straps_now = '{fs: fs_i, fsel: fsel_i, creq: creq_sel_i};

  pg_qualifier #(.SYNC_STAGES(SYNC_STAGES), .QUAL_LEN(QUAL_LEN)) u_qual (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwrgd_n_i    (pwrgd_n_i),
    .pg_low_o     (pg_low),
    .qual_valid_o (qual_valid)
  );

  strap_capture u_cap (
    .clk          (clk),
    .rst_n        (rst_n),
    .qual_valid_i (qual_valid),
    .test_mode_i  (test_mode_i),
    .straps_i     (straps_now),
    .held_o       (held),
    .locked_o     (locked_o),
    .capture_o    (capture_evt)
  );

  strap_decode u_dec (
    .held_i       (held),
    .host_code_o  (host_code_o),
    .invalid_o    (strap_invalid_o),
    .pair_a_o     (pair_a_sel_o),
    .pair_b_sst_o (pair_b_sst_o),
    .creq_xclk_o  (creq_xclk_o)
  );
endmodule

// File: rtl/strap_latch_decoder_chk.sv
module strap_latch_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       test_mode_i,
  input logic [1:0] host_code_o,
  input logic [1:0] pair_a_sel_o,
  input logic       pair_b_sst_o,
  input logic       creq_xclk_o,
  input logic       strap_invalid_o,
  input logic       locked_o,
  input logic       qual_valid,
  input logic       pg_low
);
  // R1: a lock only follows a qualified power-good low
  p_lock_needs_qual_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(qual_valid));

  // R1: qualification requires the synchronized low in the previous cycle too
  p_qual_two_cycles_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(pg_low, 2));

  // R3: an invalid code reads as 100 MHz
  p_invalid_is_100_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strap_invalid_o |-> (host_code_o == 2'd0));

  // R5: spread clock on pair B only with the dot clock on pair A
  p_pair_b_with_dot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_b_sst_o |-> (pair_a_sel_o == 2'd0));

  // R7: defaults before any capture
  p_defaults_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_o |-> (host_code_o == 2'd0 && pair_a_sel_o == 2'd0 && pair_b_sst_o
                   && !creq_xclk_o && !strap_invalid_o));

  // R8: outputs frozen once locked outside test mode
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && !test_mode_i) |=> ($stable(host_code_o) && $stable(pair_a_sel_o)
      && $stable(pair_b_sst_o) && $stable(creq_xclk_o) && $stable(strap_invalid_o)));

  // R10: lock is sticky until reset
  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> locked_o);
endmodule

bind strap_latch_decoder strap_latch_decoder_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .test_mode_i     (test_mode_i),
  .host_code_o     (host_code_o),
  .pair_a_sel_o    (pair_a_sel_o),
  .pair_b_sst_o    (pair_b_sst_o),
  .creq_xclk_o     (creq_xclk_o),
  .strap_invalid_o (strap_invalid_o),
  .locked_o        (locked_o),
  .qual_valid      (qual_valid),
  .pg_low          (pg_low)
);

// File: tb/strap_latch_decoder_test.sv
module strap_latch_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwrgd_n_i = 1'b1;
  logic       test_mode_i = 1'b0;
  logic [2:0] fs_i = 3'b000;
  logic [1:0] fsel_i = 2'b00;
  logic       creq_sel_i = 1'b0;
  logic [1:0] host_code_o;
  logic [1:0] pair_a_sel_o;
  logic       pair_b_sst_o;
  logic       creq_xclk_o;
  logic       strap_invalid_o;
  logic       locked_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_latch_decoder uut (
    .clk(clk), .rst_n(rst_n), .pwrgd_n_i(pwrgd_n_i), .test_mode_i(test_mode_i),
    .fs_i(fs_i), .fsel_i(fsel_i), .creq_sel_i(creq_sel_i),
    .host_code_o(host_code_o), .pair_a_sel_o(pair_a_sel_o), .pair_b_sst_o(pair_b_sst_o),
    .creq_xclk_o(creq_xclk_o), .strap_invalid_o(strap_invalid_o), .locked_o(locked_o)
  );

  function automatic int exp_host(int fs);
    // valid codes as {FSC,FSB,FSA}: 5->0, 1->1, 3->2, 2->3
    if (fs == 5) return 0;
    if (fs == 1) return 1;
    if (fs == 3) return 2;
    if (fs == 2) return 3;
    return 0;
  endfunction

  function automatic int exp_bad(int fs);
    return (fs == 0 || fs == 4 || fs >= 6) ? 1 : 0;
  endfunction

  function automatic int exp_pa(int fsel);
    return (fsel < 2) ? 0 : fsel - 1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic to_negedge();
    @(negedge clk);
  endtask

  task automatic do_reset();
    to_negedge();
    rst_n = 1'b0;
    pwrgd_n_i = 1'b1;
    test_mode_i = 1'b0;
    tick(2);
    to_negedge();
    rst_n = 1'b1;
  endtask

  task automatic check_all(string req, int fs, int fsel, int cr);
    check(req, "host", int'(host_code_o), exp_host(fs));
    check(req, "invalid", int'(strap_invalid_o), exp_bad(fs));
    check(req, "pair_a", int'(pair_a_sel_o), exp_pa(fsel));
    check(req, "pair_b", int'(pair_b_sst_o), (fsel == 0) ? 1 : 0);
    check(req, "creq", int'(creq_xclk_o), cr);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Sweep every strap combination through reset, qualify, lock, disturb.
    for (int fs = 0; fs < 8; fs++) begin
      for (int fsel = 0; fsel < 4; fsel++) begin
        for (int cr = 0; cr < 2; cr++) begin
          do_reset();
          #1;
          check("R10", "locked after reset", int'(locked_o), 0);
          check_all("R7", 5, 0, 0);
          to_negedge();
          fs_i = 3'(fs); fsel_i = 2'(fsel); creq_sel_i = cr[0];
          pwrgd_n_i = 1'b0;
          tick(3);
          check("R1", "locked at edge k+2", int'(locked_o), 0);
          check_all("R7", 5, 0, 0);
          tick(1);
          check("R1", "locked at edge k+3", int'(locked_o), 1);
          check_all("R2", fs, fsel, cr);  // also R3 R4 R5 R6
          // R8: disturb straps and power-good
          to_negedge();
          fs_i = ~fs_i; fsel_i = ~fsel_i; creq_sel_i = ~creq_sel_i;
          pwrgd_n_i = 1'b1;
          tick(3);
          to_negedge();
          pwrgd_n_i = 1'b0;
          tick(6);
          check_all("R8", fs, fsel, cr);
          check("R10", "locked held", int'(locked_o), 1);
        end
      end
    end

    // R1: single-cycle low pulse must not capture
    do_reset();
    fs_i = 3'b010; fsel_i = 2'b11; creq_sel_i = 1'b1;
    pwrgd_n_i = 1'b0;
    to_negedge();
    pwrgd_n_i = 1'b1;
    tick(6);
    check("R1", "glitch locked", int'(locked_o), 0);
    check_all("R1", 5, 0, 0);

    // R9: test mode re-samples
    do_reset();
    test_mode_i = 1'b1;
    fs_i = 3'b001; fsel_i = 2'b10; creq_sel_i = 1'b0;
    pwrgd_n_i = 1'b0;
    tick(4);
    check_all("R9", 1, 2, 0);
    to_negedge();
    fs_i = 3'b010; fsel_i = 2'b01; creq_sel_i = 1'b1;
    tick(1);
    check_all("R9", 2, 1, 1);
    to_negedge();
    fs_i = 3'b110;
    tick(1);
    check_all("R9", 6, 1, 1);
    // Coincidence: test mode released together with a strap change
    to_negedge();
    test_mode_i = 1'b0;
    fs_i = 3'b011; fsel_i = 2'b00; creq_sel_i = 1'b0;
    tick(1);
    check_all("R8", 6, 1, 1);
    tick(5);
    check_all("R8", 6, 1, 1);
    check("R10", "locked after test mode", int'(locked_o), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule